// File: doc/BRIEF.md
# Two-Stage Timebase Counter with Coherent Split Reads

This block keeps a 64-bit time base split into two 32-bit halves: a prescale up-counter that counts clock cycles, and a free-running counter that steps each time the up-counter reaches a programmed limit. Software reads both halves over a 32-bit register port. A read of the free-running half copies the live up-counter into a shadow register. A later read of the up-counter half returns that shadow, so the two halves always describe the same instant.

The block can also take a snapshot of both counters on an external event. Two event inputs are available, and a control bit picks which one arms the capture. The snapshot is read back with the same two-step order through its own shadow register. The free-running count is also driven out on a port for compare logic further down the chip.

Top module: `split_timebase`

## Requirements
- R1: A synchronous reset clears both counters, the read-data register, both shadow registers, the capture source bit and both capture registers to zero.
- R2: While `cnt_en` is high and the prescale value P (address 1) is nonzero, the up-counter advances once per clock. On an edge where it equals P, it returns to zero and the free-running counter increments, so the free-running counter steps once every P+1 enabled cycles and wraps past all ones.
- R3: With P equal to zero, the up-counter runs through all 2^32 values, and the free-running counter increments on the edge where the up-counter rolls from all ones to zero.
- R4: While `cnt_en` is low, both counters hold their values.
- R5: A write to address 2 loads the free-running counter and a write to address 3 loads the up-counter. On the edge of any counter write, neither counter advances.
- R6: A read of address 2 returns the free-running counter value at the read edge. On that same edge, the live up-counter is copied into the up-counter shadow.
- R7: A read of address 3 returns the up-counter shadow, not the live count. Repeated reads of address 3 with no read of address 2 in between return the same value.
- R8: Bit 0 at address 0 picks the capture source: 0 selects `evt_a` and 1 selects `evt_b`. The unselected input has no effect on the capture registers.
- R9: A rising edge on the selected source stores both live counters into the capture registers on the same edge. A level that stays high captures only once.
- R10: When a capture edge coincides with a counter step, the values stored are the ones from before the step.
- R11: A read of address 4 returns the captured free-running value and moves the captured up-counter value into a capture shadow. A read of address 5 returns that capture shadow, which stays stale until address 4 is read.
- R12: `reg_rdata` updates on the clock edge where `reg_rd` is sampled high, and holds its value on every edge without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counting enable |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address (0 ctrl, 1 prescale, 2 free-run, 3 up, 4 captured free-run, 5 captured up) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt_a | input | 1 | Capture event source 0 |
| evt_b | input | 1 | Capture event source 1 |
| frc_out | output | 32 | Free-running counter value |

## Verification
Every register read has a latency of one edge: the bench raises `reg_rd` just after a falling edge and takes `reg_rdata` at the next falling edge, after the single rising edge that loads it. Counter results are checked with counting halted. The bench counts the exact number of enabled rising edges between setting and clearing `cnt_en`, so the expected up and free-running values follow by division from the preload values. For the shadow checks, the bench predicts the up-counter value at the one edge where the free-running read is sampled. For captures, it predicts the value at the one edge where the event is first seen high. In both cases it then confirms that later edges leave those values untouched.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  localparam int REG_AW = 3;
  localparam int NSRC   = 2;
  localparam int SEL_W  = (NSRC > 1) ? $clog2(NSRC) : 1;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL   = 3'd0,
    RA_SCALE  = 3'd1,
    RA_FRC    = 3'd2,
    RA_UPC    = 3'd3,
    RA_CAPFRC = 3'd4,
    RA_CAPUPC = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/tbc_counter.sv
module tbc_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] scale,
  input  logic         ld_up,
  input  logic         ld_frc,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] up_q,
  output logic [W-1:0] frc_q
);
  logic tick;

  // zero prescale: roll over at full range
  assign tick = (scale == '0) ? (up_q == '1) : (up_q == scale);

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q  <= '0;
      frc_q <= '0;
    end else if (ld_up || ld_frc) begin
      if (ld_up)  up_q  <= ld_val;
      if (ld_frc) frc_q <= ld_val;
    end else if (en) begin
      if (tick) begin
        up_q  <= '0;
        frc_q <= frc_q + 1'b1;
      end else begin
        up_q  <= up_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tbc_capture.sv
module tbc_capture
  import tbc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic [NSRC-1:0]  evt,
  input  logic [W-1:0]     up_i,
  input  logic [W-1:0]     frc_i,
  input  logic             rd_capfrc,
  output logic [W-1:0]     cap_frc_o,
  output logic [W-1:0]     cap_shadow_o
);
  logic [NSRC-1:0] evt_prev;
  logic [NSRC-1:0] evt_rise;
  logic [W-1:0]    cap_up;
  logic            trigger;

  always_ff @(posedge clk) begin
    if (rst) evt_prev <= '0;
    else     evt_prev <= evt;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_rise
    assign evt_rise[i] = evt[i] & ~evt_prev[i];
  end

  assign trigger = evt_rise[sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_up       <= '0;
      cap_frc_o    <= '0;
      cap_shadow_o <= '0;
    end else begin
      if (trigger) begin
        cap_up    <= up_i;
        cap_frc_o <= frc_i;
      end
      if (rd_capfrc) cap_shadow_o <= cap_up;
    end
  end
endmodule

// File: rtl/tbc_regif.sv
module tbc_regif
  import tbc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [REG_AW-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      up_i,
  input  logic [W-1:0]      frc_i,
  input  logic [W-1:0]      capfrc_i,
  input  logic [W-1:0]      capshadow_i,
  output logic [W-1:0]      rdata,
  output logic [SEL_W-1:0]  sel,
  output logic [W-1:0]      scale,
  output logic              ld_up,
  output logic              ld_frc,
  output logic              rd_capfrc
);
  logic [W-1:0] up_shadow;
  logic [W-1:0] mux;
  logic         rd_frc;

  assign ld_up     = wr && (addr == RA_UPC);
  assign ld_frc    = wr && (addr == RA_FRC);
  assign rd_frc    = rd && (addr == RA_FRC);
  assign rd_capfrc = rd && (addr == RA_CAPFRC);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel   <= '0;
      scale <= '0;
    end else if (wr) begin
      if (addr == RA_CTRL)  sel   <= wdata[SEL_W-1:0];
      if (addr == RA_SCALE) scale <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         up_shadow <= '0;
    else if (rd_frc) up_shadow <= up_i;
  end

  always_comb begin
    mux = '0;
    case (addr)
      RA_CTRL:   mux[SEL_W-1:0] = sel;
      RA_SCALE:  mux = scale;
      RA_FRC:    mux = frc_i;
      RA_UPC:    mux = up_shadow;
      RA_CAPFRC: mux = capfrc_i;
      RA_CAPUPC: mux = capshadow_i;
      default:   mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= mux;
  end
endmodule

// File: rtl/split_timebase.sv
module split_timebase
  import tbc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic              evt_a,
  input  logic              evt_b,
  output logic [CNT_W-1:0]  frc_out
);
  logic [CNT_W-1:0] up_cnt;
  logic [CNT_W-1:0] frc_cnt;
  logic [CNT_W-1:0] scale;
  logic [CNT_W-1:0] cap_frc;
  logic [CNT_W-1:0] cap_shadow;
  logic [SEL_W-1:0] cap_sel;
  logic             ld_up;
  logic             ld_frc;
  logic             rd_capfrc;
  logic [NSRC-1:0]  evt_vec;

  assign evt_vec = {evt_b, evt_a};
  assign frc_out = frc_cnt;

  tbc_counter #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .en     (cnt_en),
    .scale  (scale),
    .ld_up  (ld_up),
    .ld_frc (ld_frc),
    .ld_val (reg_wdata),
    .up_q   (up_cnt),
    .frc_q  (frc_cnt)
  );

  tbc_capture #(.W(CNT_W)) u_cap (
    .clk          (clk),
    .rst          (rst),
    .sel          (cap_sel),
    .evt          (evt_vec),
    .up_i         (up_cnt),
    .frc_i        (frc_cnt),
    .rd_capfrc    (rd_capfrc),
    .cap_frc_o    (cap_frc),
    .cap_shadow_o (cap_shadow)
  );

  tbc_regif #(.W(CNT_W)) u_reg (
    .clk         (clk),
    .rst         (rst),
    .wr          (reg_wr),
    .rd          (reg_rd),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .up_i        (up_cnt),
    .frc_i       (frc_cnt),
    .capfrc_i    (cap_frc),
    .capshadow_i (cap_shadow),
    .rdata       (reg_rdata),
    .sel         (cap_sel),
    .scale       (scale),
    .ld_up       (ld_up),
    .ld_frc      (ld_frc),
    .rd_capfrc   (rd_capfrc)
  );
endmodule

// File: rtl/split_timebase_chk.sv
module split_timebase_chk
  import tbc_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cnt_en,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [REG_AW-1:0] reg_addr,
  input logic [W-1:0]      reg_rdata,
  input logic [W-1:0]      frc_out,
  input logic              evt_a,
  input logic              evt_b,
  input logic [SEL_W-1:0]  cap_sel,
  input logic [W-1:0]      cap_frc
);
  logic prev_upc_rd;
  logic upc_rd;
  logic src_now;

  assign upc_rd  = reg_rd && (reg_addr == RA_UPC);
  assign src_now = (cap_sel == '0) ? evt_a : evt_b;

  always_ff @(posedge clk) begin
    if (rst) prev_upc_rd <= 1'b0;
    else     prev_upc_rd <= upc_rd;
  end

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (frc_out == '0 && reg_rdata == '0)); // R1

  AST_FRC_STEP: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !reg_wr) |=> (frc_out == $past(frc_out) || frc_out == $past(frc_out) + 1'b1)); // R2

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !reg_wr) |=> $stable(frc_out)); // R4

  AST_FRC_READ: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == RA_FRC) |=> (reg_rdata == $past(frc_out))); // R6

  AST_UPC_REPEAT: assert property (@(posedge clk) disable iff (rst)
    (upc_rd && prev_upc_rd) |=> $stable(reg_rdata)); // R7

  AST_CAP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !src_now |=> $stable(cap_frc)); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata)); // R12
endmodule

bind split_timebase split_timebase_chk #(.W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cnt_en    (cnt_en),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .frc_out   (frc_out),
  .evt_a     (evt_a),
  .evt_b     (evt_b),
  .cap_sel   (cap_sel),
  .cap_frc   (cap_frc)
);

// File: tb/tb_split_timebase.sv
module tb_split_timebase;
  localparam int W = 32;
  localparam int NV = 6;
  // each vector: {up preload, free-run preload, prescale, enabled cycles}
  localparam logic [4*W-1:0] VEC [NV] = '{
    {32'd0,          32'd0,          32'd9, 32'd25},
    {32'd3,          32'd100,        32'd4, 32'd12},
    {32'd0,          32'hFFFF_FFFF,  32'd1, 32'd5},
    {32'hFFFF_FFFE,  32'd5,          32'd0, 32'd3},
    {32'd0,          32'd7,          32'd0, 32'd10},
    {32'd2,          32'd0,          32'd2, 32'd0}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cnt_en = 1'b0;
  logic         reg_wr = 1'b0;
  logic         reg_rd = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         evt_a = 1'b0;
  logic         evt_b = 1'b0;
  logic [W-1:0] frc_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] rv;

  always #10 clk = ~clk;

  split_timebase #(.CNT_W(W)) dut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_a(evt_a), .evt_b(evt_b), .frc_out(frc_out)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [W-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [W-1:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 frc_out", frc_out, '0);
    check("R1 rdata", reg_rdata, '0);
    rd_reg(3'd2, rv); check("R1 free-run", rv, '0);
    rd_reg(3'd3, rv); check("R1 up shadow", rv, '0);
    rd_reg(3'd5, rv); check("R1 capture shadow", rv, '0);

    // vector table: R2, R3, R4
    for (int v = 0; v < NV; v++) begin
      logic [W-1:0] u0, f0, p, n, ef, eu;
      logic [W:0]   sum;
      {u0, f0, p, n} = VEC[v];
      cnt_en = 1'b0;
      wr_reg(3'd3, u0);
      wr_reg(3'd2, f0);
      wr_reg(3'd1, p);
      if (n != 0) begin
        cnt_en = 1'b1;
        repeat (int'(n)) @(negedge clk);
        cnt_en = 1'b0;
      end
      if (p == 0) begin
        sum = {1'b0, u0} + {1'b0, n};
        ef = f0 + {{(W-1){1'b0}}, sum[W]};
        eu = sum[W-1:0];
      end else begin
        ef = f0 + (u0 + n) / (p + 1);
        eu = (u0 + n) % (p + 1);
      end
      repeat (2) @(negedge clk);  // R4: disabled cycles change nothing
      rd_reg(3'd2, rv); check(p == 0 ? "R3 free-run" : "R2 free-run", rv, ef);
      rd_reg(3'd3, rv); check(p == 0 ? "R3 up" : "R2 up", rv, eu);
      check("R4 frc_out held", frc_out, ef);
    end

    // R6 / R7: shadow holds the up count from the free-run read edge
    wr_reg(3'd1, 32'd9);
    wr_reg(3'd3, 32'd0);
    wr_reg(3'd2, 32'd0);
    cnt_en = 1'b1;
    repeat (3) @(negedge clk);
    rd_reg(3'd2, rv); check("R6 free-run live", rv, 32'd0);
    repeat (4) @(negedge clk);
    rd_reg(3'd3, rv); check("R7 up shadow", rv, 32'd3);
    rd_reg(3'd3, rv); check("R7 up shadow repeat", rv, 32'd3);
    cnt_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R12 rdata held", reg_rdata, 32'd3);

    // R5: write edge suppresses counting
    wr_reg(3'd3, 32'd2);
    cnt_en = 1'b1;
    wr_reg(3'd2, 32'h50);
    cnt_en = 1'b0;
    rd_reg(3'd2, rv); check("R5 free-run load", rv, 32'h50);
    rd_reg(3'd3, rv); check("R5 up unchanged", rv, 32'd2);

    // capture tests
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    wr_reg(3'd3, 32'd7);
    wr_reg(3'd2, 32'h100);
    wr_reg(3'd0, 32'd0);
    evt_b = 1'b1; @(negedge clk); evt_b = 1'b0; @(negedge clk);
    rd_reg(3'd4, rv); check("R8 unselected ignored", rv, 32'd0);
    rd_reg(3'd5, rv); check("R8 unselected ignored up", rv, 32'd0);
    evt_a = 1'b1; @(negedge clk);
    wr_reg(3'd3, 32'd8);
    wr_reg(3'd2, 32'h200);
    repeat (2) @(negedge clk);
    rd_reg(3'd5, rv); check("R11 capture shadow stale", rv, 32'd0);
    rd_reg(3'd4, rv); check("R9 captured free-run once", rv, 32'h100);
    rd_reg(3'd5, rv); check("R11 captured up", rv, 32'd7);
    evt_a = 1'b0;
    wr_reg(3'd0, 32'd1);
    rd_reg(3'd0, rv); check("R8 select bit", rv, 32'd1);
    evt_a = 1'b1; @(negedge clk); evt_a = 1'b0; @(negedge clk);
    rd_reg(3'd4, rv); check("R8 evt_a ignored when b selected", rv, 32'h100);
    evt_b = 1'b1; @(negedge clk); evt_b = 1'b0; @(negedge clk);
    rd_reg(3'd4, rv); check("R8 evt_b capture", rv, 32'h200);
    rd_reg(3'd5, rv); check("R8 evt_b capture up", rv, 32'd8);

    // R10: capture on a step edge keeps pre-step values
    wr_reg(3'd0, 32'd0);
    wr_reg(3'd1, 32'd3);
    wr_reg(3'd3, 32'd3);
    wr_reg(3'd2, 32'd9);
    evt_a = 1'b1; cnt_en = 1'b1;
    @(negedge clk);
    evt_a = 1'b0; cnt_en = 1'b0;
    rd_reg(3'd4, rv); check("R10 captured free-run", rv, 32'd9);
    rd_reg(3'd5, rv); check("R10 captured up", rv, 32'd3);
    rd_reg(3'd2, rv); check("R10 free-run stepped", rv, 32'd10);
    rd_reg(3'd3, rv); check("R10 up cleared", rv, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule